// File: doc/BRIEF.md
# Page Write Staging Buffer and Programming Sequencer

This block sits behind the command decoder of a serial memory and owns the write path. When the decoder sees a write command it pulses `cmd_start` with the start address. The unit checks that writing is permitted and that the address lies outside the protected region. If both hold, it collects the data bytes that follow into a 32-entry page buffer, marking each filled entry as valid. The byte offset advances after every byte and wraps inside the page, so a stream longer than a page overwrites its own earlier entries. Bytes that arrive while no frame is open are ignored.

When the decoder reports the end of the frame, the unit decides whether to program. It programs only if the chip-select rise landed exactly on a byte boundary and at least one complete byte was taken. Otherwise the buffer is thrown away. Programming walks the 32 page offsets one per clock and issues an array write for each valid entry only. It then holds `busy` for a write-cycle time taken from `wc_time`. In the last busy cycle it pulses `wel_clr` so that the decoder drops its write-enable latch.

Top module: `page_prog_seq`

## Requirements
- R1: The array write address keeps the upper bits (bits 12..5) of the start address for the whole command. The lower 5 bits begin at the start offset and increase by one per received byte, wrapping from 31 to 0.
- R2: When more than 32 bytes arrive in one frame, the later byte replaces the earlier one at the same page offset, and only the last value is written.
- R3: Programming begins (`busy` rises) only on a `frame_end` that has `frame_aligned`=1 and at least one byte taken, counting a byte strobed in the same cycle. A misaligned end or a frame with no byte discards the buffer and `busy` stays 0.
- R4: Once programming begins, `busy` stays 1 for exactly 32 + `wc_time` + 1 clocks. The value of `wc_time` is captured at the frame end.
- R5: `wel_clr` is a single-cycle pulse asserted in the last cycle of `busy`, exactly once per programming cycle.
- R6: During programming, `mem_we` is asserted once for each valid buffer entry, with that entry's address and data. Page locations that received no byte are not written.
- R7: Protection levels on `prot_lvl`: 0 = none, 1 = addresses 0x1800..0x1FFF, 2 = 0x1000..0x1FFF, 3 = the whole array. A command whose start address is protected is dropped: no write, no `busy`, no `wel_clr`.
- R8: A command issued while `wel_in`=0 is dropped, with no write, no `busy` and no `wel_clr`.
- R9: `cmd_start`, byte strobes and frame ends that arrive while `busy` is 1 have no effect. No array write occurs outside `busy`.
- R10: After reset, `busy`, `mem_we` and `wel_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_start | input | 1 | Pulse: a write command has been decoded |
| start_addr | input | 13 | Byte address carried by the command |
| wel_in | input | 1 | Write-enable latch state (writing permitted) |
| prot_lvl | input | 2 | Block protection level |
| byte_vld | input | 1 | Pulse: one complete data byte received |
| byte_data | input | 8 | Received data byte |
| frame_end | input | 1 | Pulse: chip select has risen |
| frame_aligned | input | 1 | The chip-select rise fell on a byte boundary |
| wc_time | input | 16 | Write-cycle hold time in clocks |
| busy | output | 1 | Internal write cycle in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |
| mem_we | output | 1 | Array byte write strobe |
| mem_addr | output | 13 | Array byte address |
| mem_wdata | output | 8 | Array byte data |

## Verification
The last data byte and the frame end can reach the unit in the same clock. The byte must then be stored and also counted toward the decision to start programming. The bench provokes this by raising `byte_vld` and `frame_end` together at the end of a wrapped 34-byte stream, and again with a single-byte frame. It judges the outcome by requiring the start of `busy` and the written image to match a behavioural model that is compared on every clock, together with explicit readbacks of the wrapped page offsets.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_COMMIT = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ppw_wp_check.sv
module ppw_wp_check #(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        lvl,
  output logic              hit
);
  logic top_half;
  logic top_quarter;

  always_comb begin
    top_half    = addr[ADDR_W-1];
    top_quarter = addr[ADDR_W-1] & addr[ADDR_W-2];
    unique case (lvl)
      2'd0:    hit = 1'b0;
      2'd1:    hit = top_quarter;
      2'd2:    hit = top_half;
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/ppw_page_buf.sv
module ppw_page_buf #(
  parameter int OFS_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OFS_W-1:0]  load_ofs,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid_nxt
);
  localparam int DEPTH = 1 << OFS_W;

  logic [OFS_W-1:0]  ptr_q, ptr_d;
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [DEPTH-1:0]  wr_sel;
  logic [DATA_W-1:0] data_q [DEPTH];

  always_comb begin
    wr_sel = '0;
    if (wr_en) wr_sel[ptr_q] = 1'b1;
    ptr_d = ptr_q;
    vld_d = vld_q;
    if (load) begin
      ptr_d = load_ofs;
      vld_d = '0;
    end else if (wr_en) begin
      ptr_d = ptr_q + 1'b1;
      vld_d = vld_q | wr_sel;
    end
    any_valid_nxt = |vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      vld_q <= '0;
    end else if (load || wr_en) begin
      ptr_q <= ptr_d;
      vld_q <= vld_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         data_q[g] <= '0;
      else if (wr_sel[g]) data_q[g] <= wr_data;
    end
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/ppw_seq.sv
module ppw_seq
  import ppw_pkg::*;
#(
  parameter int OFS_W = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  logic             frame_end,
  input  logic             frame_aligned,
  input  logic             any_valid_nxt,
  input  logic [CNT_W-1:0] wc_time,
  output logic             load,
  output logic             filling,
  output logic             committing,
  output logic [OFS_W-1:0] idx,
  output logic             busy,
  output logic             wel_clr
);
  seq_state_t       st_q, st_d;
  logic [OFS_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic [CNT_W-1:0] wc_q, wc_d;
  logic             hold_end;

  assign hold_end = (st_q == ST_HOLD) && (tmr_q == wc_q);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    tmr_d = tmr_q;
    wc_d  = wc_q;
    load  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          load = 1'b1;
          st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (frame_end) begin
          if (frame_aligned && any_valid_nxt) begin
            st_d  = ST_COMMIT;
            idx_d = '0;
            wc_d  = wc_time;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_COMMIT: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == '1) begin
          st_d  = ST_HOLD;
          tmr_d = '0;
        end
      end
      default: begin
        if (hold_end) st_d = ST_IDLE;
        else          tmr_d = tmr_q + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      tmr_q <= '0;
      wc_q  <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      tmr_q <= tmr_d;
      wc_q  <= wc_d;
    end
  end

  assign filling    = (st_q == ST_FILL);
  assign committing = (st_q == ST_COMMIT);
  assign idx        = idx_q;
  assign busy       = (st_q == ST_COMMIT) || (st_q == ST_HOLD);
  assign wel_clr    = hold_end;
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 5,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              wel_in,
  input  logic [1:0]        prot_lvl,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              frame_end,
  input  logic              frame_aligned,
  input  logic [CNT_W-1:0]  wc_time,
  output logic              busy,
  output logic              wel_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic              prot_hit;
  logic              start_ok;
  logic              load;
  logic              filling;
  logic              committing;
  logic [OFS_W-1:0]  idx;
  logic              any_valid_nxt;
  logic              rd_valid;
  logic [PAGE_W-1:0] page_q;

  ppw_wp_check #(.ADDR_W(ADDR_W)) u_wp (
    .addr (start_addr),
    .lvl  (prot_lvl),
    .hit  (prot_hit)
  );

  assign start_ok = cmd_start && wel_in && !prot_hit;

  ppw_seq #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_ok      (start_ok),
    .frame_end     (frame_end),
    .frame_aligned (frame_aligned),
    .any_valid_nxt (any_valid_nxt),
    .wc_time       (wc_time),
    .load          (load),
    .filling       (filling),
    .committing    (committing),
    .idx           (idx),
    .busy          (busy),
    .wel_clr       (wel_clr)
  );

  ppw_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .load_ofs      (start_addr[OFS_W-1:0]),
    .wr_en         (filling && byte_vld),
    .wr_data       (byte_data),
    .rd_idx        (idx),
    .rd_data       (mem_wdata),
    .rd_valid      (rd_valid),
    .any_valid_nxt (any_valid_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    page_q <= '0;
    else if (load) page_q <= start_addr[ADDR_W-1:OFS_W];
  end

  assign mem_we   = committing && rd_valid;
  assign mem_addr = {page_q, idx};
endmodule

// File: rtl/ppw_chk.sv
module ppw_chk #(
  parameter int ADDR_W = 13,
  parameter int OFS_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_end,
  input logic              frame_aligned,
  input logic              busy,
  input logic              wel_clr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  a_r1_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W])));

  a_r3_start_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_end && frame_aligned));

  a_r4_fall_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(wel_clr));

  a_r5_clr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy);

  a_r5_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wel_clr);

  a_r9_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
endmodule

bind page_prog_seq ppw_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_end     (frame_end),
  .frame_aligned (frame_aligned),
  .busy          (busy),
  .wel_clr       (wel_clr),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr)
);

// File: tb/tb_page_prog_seq.sv
module tb_page_prog_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [12:0] start_addr = '0;
  logic        wel_in = 1'b0;
  logic [1:0]  prot_lvl = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        frame_end = 1'b0;
  logic        frame_aligned = 1'b0;
  logic [15:0] wc_time = 16'd5;
  logic        busy, wel_clr, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata;

  page_prog_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
    .wel_in(wel_in), .prot_lvl(prot_lvl), .byte_vld(byte_vld), .byte_data(byte_data),
    .frame_end(frame_end), .frame_aligned(frame_aligned), .wc_time(wc_time),
    .busy(busy), .wel_clr(wel_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference
  int ms = 0, mptr = 0, mpage = 0, midx = 0, mtmr = 0, mwc = 0;
  int mbuf [32];
  bit mvalid [32];
  logic [7:0] mem_img [int];
  int busy_len = 0, busy_rises = 0, clr_cnt = 0;
  bit prev_busy = 0;

  function automatic bit is_prot(int a, int lvl);
    if (lvl == 3) return 1;
    if (lvl == 2) return a >= 'h1000;
    if (lvl == 1) return a >= 'h1800;
    return 0;
  endfunction

  function automatic bit any_valid();
    foreach (mvalid[i]) if (mvalid[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; midx = 0; mtmr = 0; mwc = 0; mptr = 0; mpage = 0;
      foreach (mvalid[i]) begin mvalid[i] = 0; mbuf[i] = 0; end
    end else begin
      case (ms)
        0: if (cmd_start && wel_in && !is_prot(int'(start_addr), int'(prot_lvl))) begin
             ms = 1; mptr = start_addr % 32; mpage = start_addr / 32;
             foreach (mvalid[i]) mvalid[i] = 0;
           end
        1: begin
             if (byte_vld) begin
               mbuf[mptr] = byte_data; mvalid[mptr] = 1; mptr = (mptr + 1) % 32;
             end
             if (frame_end) begin
               if (frame_aligned && any_valid()) begin
                 ms = 2; midx = 0; mwc = wc_time;
               end else ms = 0;
             end
           end
        2: begin
             midx = midx + 1;
             if (midx == 32) begin ms = 3; midx = 0; mtmr = 0; end
           end
        default: if (mtmr == mwc) ms = 0; else mtmr = mtmr + 1;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_busy, e_we, e_clr;
      int e_addr;
      e_busy = (ms == 2) || (ms == 3);
      e_we   = (ms == 2) && mvalid[midx];
      e_clr  = (ms == 3) && (mtmr == mwc);
      e_addr = mpage * 32 + midx;
      chk(busy == e_busy, "R4 busy", busy, e_busy);
      chk(wel_clr == e_clr, "R5 wel_clr", wel_clr, e_clr);
      chk(mem_we == e_we, "R6 mem_we", mem_we, e_we);
      if (e_we) begin
        chk(mem_addr == e_addr, "R1 mem_addr", mem_addr, e_addr);
        chk(mem_wdata == mbuf[midx], "R2 mem_wdata", mem_wdata, mbuf[midx]);
      end
      if (mem_we) mem_img[int'(mem_addr)] = mem_wdata;
      if (busy) busy_len++;
      if (busy && !prev_busy) busy_rises++;
      if (wel_clr) clr_cnt++;
      prev_busy = busy;
    end
  end

  task automatic cmd(int a, int lvl, bit wel);
    @(negedge clk);
    cmd_start = 1; start_addr = a[12:0]; prot_lvl = lvl[1:0]; wel_in = wel;
    @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic put(int d, bit fe, bit al);
    @(negedge clk);
    byte_vld = 1; byte_data = d[7:0]; frame_end = fe; frame_aligned = al;
    @(negedge clk);
    byte_vld = 0; frame_end = 0; frame_aligned = 0;
  endtask

  task automatic fend(bit al);
    @(negedge clk);
    frame_end = 1; frame_aligned = al;
    @(negedge clk);
    frame_end = 0; frame_aligned = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_stats();
    busy_len = 0; busy_rises = 0; clr_cnt = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R10 reset busy", busy, 0);
    chk(mem_we == 0, "R10 reset mem_we", mem_we, 0);
    chk(wel_clr == 0, "R10 reset wel_clr", wel_clr, 0);

    // normal write, separate frame end
    clear_stats();
    wc_time = 16'd5;
    cmd('h0103, 0, 1);
    put('h11, 0, 0); put('h22, 0, 0); put('h33, 0, 0); put('h44, 0, 0);
    fend(1);
    wc_time = 16'd9;
    settle();
    chk(busy_len == 38, "R4 busy length", busy_len, 38);
    chk(clr_cnt == 1, "R5 clear count", clr_cnt, 1);
    chk(mem_img.exists('h0103) && mem_img['h0103] == 8'h11, "R1 first byte", mem_img['h0103], 'h11);
    chk(mem_img.exists('h0106) && mem_img['h0106] == 8'h44, "R1 fourth byte", mem_img['h0106], 'h44);
    chk(!mem_img.exists('h0102), "R6 untouched below", mem_img.exists('h0102), 0);
    chk(!mem_img.exists('h0107), "R6 untouched above", mem_img.exists('h0107), 0);

    // wrapped stream, last byte coincident with frame end
    clear_stats();
    wc_time = 16'd2;
    cmd('h02FE, 0, 1);
    for (int k = 0; k < 34; k++) put('h40 + k, k == 33, k == 33);
    settle();
    chk(busy_rises == 1, "R3 coincident start", busy_rises, 1);
    chk(mem_img['h02FE] == 8'h60, "R2 offset30 overwritten", mem_img['h02FE], 'h60);
    chk(mem_img['h02FF] == 8'h61, "R2 offset31 overwritten", mem_img['h02FF], 'h61);
    chk(mem_img['h02E0] == 8'h42, "R1 wrap to offset0", mem_img['h02E0], 'h42);
    chk(mem_img['h02FD] == 8'h5F, "R1 offset29", mem_img['h02FD], 'h5F);
    chk(!mem_img.exists('h0300), "R1 page held", mem_img.exists('h0300), 0);

    // single byte coincident with frame end
    clear_stats();
    cmd('h0A10, 0, 1);
    put('h5A, 1, 1);
    settle();
    chk(mem_img.exists('h0A10) && mem_img['h0A10] == 8'h5A, "R3 single coincident", mem_img['h0A10], 'h5A);

    // misaligned end
    clear_stats();
    cmd('h0400, 0, 1);
    put('h01, 0, 0); put('h02, 0, 0);
    fend(0);
    settle();
    chk(busy_rises == 0, "R3 misaligned no busy", busy_rises, 0);
    chk(!mem_img.exists('h0400), "R3 misaligned no write", mem_img.exists('h0400), 0);

    // aligned end without data
    clear_stats();
    cmd('h0500, 0, 1);
    fend(1);
    settle();
    chk(busy_rises == 0, "R3 empty frame no busy", busy_rises, 0);

    // write not enabled
    clear_stats();
    cmd('h0600, 0, 0);
    put('h77, 1, 1);
    settle();
    chk(busy_rises == 0 && clr_cnt == 0, "R8 disabled dropped", busy_rises, 0);
    chk(!mem_img.exists('h0600), "R8 no write", mem_img.exists('h0600), 0);

    // protection levels
    clear_stats();
    cmd('h1900, 1, 1); put('h81, 1, 1); settle();
    chk(!mem_img.exists('h1900) && clr_cnt == 0, "R7 lvl1 top quarter", clr_cnt, 0);
    cmd('h1000, 2, 1); put('h82, 1, 1); settle();
    chk(!mem_img.exists('h1000) && clr_cnt == 0, "R7 lvl2 top half", clr_cnt, 0);
    cmd('h0020, 3, 1); put('h83, 1, 1); settle();
    chk(!mem_img.exists('h0020) && busy_rises == 0, "R7 lvl3 all", busy_rises, 0);
    cmd('h1400, 1, 1); put('h84, 1, 1); settle();
    chk(mem_img.exists('h1400) && mem_img['h1400] == 8'h84, "R7 lvl1 lower allowed", mem_img['h1400], 'h84);
    cmd('h0FE0, 2, 1); put('h85, 1, 1); settle();
    chk(mem_img.exists('h0FE0) && mem_img['h0FE0] == 8'h85, "R7 lvl2 lower allowed", mem_img['h0FE0], 'h85);

    // activity during busy
    clear_stats();
    wc_time = 16'd20;
    cmd('h0700, 0, 1);
    put('h90, 1, 1);
    cmd('h0740, 0, 1);
    put('h99, 1, 1);
    settle();
    chk(busy_rises == 1, "R9 one cycle only", busy_rises, 1);
    chk(!mem_img.exists('h0740), "R9 busy command ignored", mem_img.exists('h0740), 0);
    chk(mem_img['h0700] == 8'h90, "R9 first kept", mem_img['h0700], 'h90);

    // byte strobes with no open frame
    clear_stats();
    put('hEE, 1, 1);
    settle();
    chk(busy_rises == 0, "R9 idle strobe ignored", busy_rises, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule